// File: doc/BRIEF.md
# Stepper Phase Control Front End with Serial Configuration

This block is the control front end of a four-phase unipolar stepper driver. Four phase inputs control four low-side gate enables. Driving all four phase inputs low at the same time opens a programming window. While the window is open, every gate enable is held off. Serial data, clocked by a separate serial clock, is shifted into a six-bit shadow word. When any phase input goes high again, the window closes and the shadow word is copied into the active configuration in one step. The outputs therefore never act on a partly loaded word.

The active configuration selects between two operating modes:
- **Simplified mode:** the phase inputs act as two polarity selects, an enable and a current-reduction request.
- **Full mode:** each phase input drives its own gate enable directly.

The configuration also supplies three exports to the current regulator outside this block: a two-bit current-reference code, a two-bit open-loop on-time code and an open-loop/closed-loop select.

A synchronous active-low reset clears both configuration words, which selects simplified mode. It also holds all outputs off.

Top module: `stp_ctl_top`

## Requirements
- R1: Programming mode is active exactly while the registered phase inputs are all zero. A serial bit is accepted only while programming mode is active.
- R2: While in programming mode, all four gate enables and the current-reduction output are 0.
- R3: Each rising edge of `ser_clk` shifts `ser_data` into the least significant end of the shadow word, so the most significant bit (C5) enters first. After the window closes, the last six bits shifted in form C5..C0.
- R4: Simplified mode is selected when C5=0, with these mappings:
  - When `phase_in[2]`=1, `gate_en[0]`=`phase_in[0]`, `gate_en[1]`=NOT `phase_in[0]`, `gate_en[2]`=`phase_in[1]` and `gate_en[3]`=NOT `phase_in[1]`.
  - When `phase_in[2]`=0, all gate enables are 0.
  - `cur_reduce` equals `phase_in[3]`.
- R5: In full mode (C5=1), `gate_en[i]` equals `phase_in[i]` for each i, and `cur_reduce` is 0.
- R6: The configuration exports do not change while the window is open. When the window closes, the shadow word becomes the active configuration.
- R7: While `rst_n` is low at a clock edge, both configuration words are cleared and all outputs become 0 after that edge.
- R8: The exports map to configuration bits as follows: `iref_code` = C1:C0, `ontime_code` = C3:C2, `open_loop` = C4 and `full_mode` = C5.
- R9: Serial clock edges that occur outside programming mode leave the shadow word unchanged.
- R10: Gate enables, `cur_reduce` and the configuration exports respond to a change of `phase_in` at the second rising clock edge after that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_in | input | 4 | Phase inputs; all zero opens programming mode |
| ser_clk | input | 1 | Serial clock, asynchronous, sampled on its rising edge |
| ser_data | input | 1 | Serial configuration data |
| gate_en | output | 4 | Low-side gate enables |
| cur_reduce | output | 1 | Current-reduction request to the regulator |
| iref_code | output | 2 | Current-reference selection code |
| ontime_code | output | 2 | Open-loop on-time code |
| open_loop | output | 1 | 1 selects open-loop current chopping |
| full_mode | output | 1 | 1 when full operating mode is active |

## Verification
A new `phase_in` value is registered at the first clock edge. The gate enables, `cur_reduce` and a freshly committed configuration all appear after the second edge. The bench therefore drives `phase_in` on a falling edge, lets two rising edges pass, and compares at the next falling edge.

A serial bit passes through a two-stage synchronizer and an edge detector, so it reaches the shadow word about three clock cycles after its `ser_clk` edge. The bench holds each serial level for four cycles and adds four quiet cycles after the last bit before it closes the window. Between these points, the configuration exports are checked to stay at the value committed earlier.

// File: rtl/stp_ctl_pkg.sv
// Shared types and constants for the stepper control front end.
// Assumes a four-phase unipolar winding arrangement: two winding pairs,
// each pair driven by two low-side switches.
package stp_ctl_pkg;

    localparam int NPH     = 4;           // phase inputs and gate enables
    localparam int NPAIR   = NPH / 2;     // winding pairs
    localparam int CFG_W   = 6;           // configuration word width
    localparam int IDX_EN  = 2;           // simplified mode: enable input
    localparam int IDX_RED = 3;           // simplified mode: reduction input

    // Configuration word; packed order puts C5 at the MSB, C0 at the LSB.
    typedef struct packed {
        logic       full;       // C5: 1 = full mode, 0 = simplified mode
        logic       open_loop;  // C4: open-loop chopping select
        logic [1:0] ontime;     // C3:C2: open-loop on-time code
        logic [1:0] iref;       // C1:C0: current-reference code
    } cfg_t;

endpackage

// File: rtl/stp_sync.sv
// Multi-stage synchronizer for asynchronous single-bit or narrow inputs.
// Assumes every bit is independent (no bus coherency is required).
module stp_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/stp_serial_shadow.sv
// Serial loader: detects rising edges of the synchronized serial clock and
// shifts the synchronized data bit into the shadow word, MSB first.
// Assumes clock and data arrive through matched synchronizer stages, so
// the data bit is stable around each detected edge.
module stp_serial_shadow
    import stp_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic prog,        // programming window open
    input  logic sclk_s,      // synchronized serial clock
    input  logic sdat_s,      // synchronized serial data
    output cfg_t shadow
);

    logic             sclk_d;
    logic             sclk_rise;
    logic [CFG_W-1:0] shadow_q;

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_d;

    // Shift one bit per serial edge, only inside the programming window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (sclk_rise && prog) begin
            shadow_q <= {shadow_q[CFG_W-2:0], sdat_s};
        end
    end

    assign shadow = cfg_t'(shadow_q);

endmodule

// File: rtl/stp_mode_dec.sv
// Combinational mode decoder: maps phase inputs to gate enables and a
// current-reduction request according to the operating mode.
// Assumes 'prog' blanks everything; the caller registers the results.
module stp_mode_dec
    import stp_ctl_pkg::*;
(
    input  logic [NPH-1:0] phase,
    input  cfg_t           cfg,
    input  logic           prog,
    output logic [NPH-1:0] gate,
    output logic           reduce
);

    logic [NPH-1:0] gate_simple;
    logic           simple_en;

    assign simple_en = phase[IDX_EN];

    // Simplified mode: one polarity select per winding pair.
    for (genvar w = 0; w < NPAIR; w++) begin : g_pair
        assign gate_simple[2*w]   = simple_en &  phase[w];
        assign gate_simple[2*w+1] = simple_en & ~phase[w];
    end

    // Select the mode and apply programming-window blanking.
    always_comb begin
        if (prog) begin
            gate   = '0;
            reduce = 1'b0;
        end else if (cfg.full) begin
            gate   = phase;
            reduce = 1'b0;
        end else begin
            gate   = gate_simple;
            reduce = phase[IDX_RED];
        end
    end

endmodule

// File: rtl/stp_ctl_top.sv
// Stepper control front end top level. It registers the phase inputs,
// detects the all-low programming window, loads the serial shadow word,
// commits it to the active configuration when the window closes, and
// registers the decoded gate enables.
// Assumes phase_in is synchronous to clk; ser_clk/ser_data are asynchronous.
module stp_ctl_top
    import stp_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] phase_in,
    input  logic           ser_clk,
    input  logic           ser_data,
    output logic [NPH-1:0] gate_en,
    output logic           cur_reduce,
    output logic [1:0]     iref_code,
    output logic [1:0]     ontime_code,
    output logic           open_loop,
    output logic           full_mode
);

    logic [NPH-1:0] phase_q;
    logic           prog_now;
    logic           prog_d;
    logic           leaving;
    logic [1:0]     ser_s;
    cfg_t           shadow;
    cfg_t           active;
    cfg_t           cfg_eff;
    logic [NPH-1:0] gate_nx;
    logic           reduce_nx;

    // Register the phase inputs; reset looks like the programming pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_in;
    end

    assign prog_now = (phase_q == '0);

    // Track the previous window state to find the closing cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prog_d <= 1'b1;
        else        prog_d <= prog_now;
    end

    assign leaving = prog_d & ~prog_now;

    stp_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_clk, ser_data}),
        .q     (ser_s)
    );

    stp_serial_shadow i_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .prog   (prog_now),
        .sclk_s (ser_s[1]),
        .sdat_s (ser_s[0]),
        .shadow (shadow)
    );

    // The closing cycle already decodes with the new word.
    assign cfg_eff = leaving ? shadow : active;

    // Hold the active configuration; take the shadow word on window exit.
    always_ff @(posedge clk) begin
        if (!rst_n) active <= '0;
        else        active <= cfg_eff;
    end

    stp_mode_dec i_dec (
        .phase  (phase_q),
        .cfg    (cfg_eff),
        .prog   (prog_now),
        .gate   (gate_nx),
        .reduce (reduce_nx)
    );

    // Register the decoded drive outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_en    <= '0;
            cur_reduce <= 1'b0;
        end else begin
            gate_en    <= gate_nx;
            cur_reduce <= reduce_nx;
        end
    end

    assign iref_code   = active.iref;
    assign ontime_code = active.ontime;
    assign open_loop   = active.open_loop;
    assign full_mode   = active.full;

endmodule

// File: rtl/stp_ctl_chk.sv
// Property checker for stp_ctl_top, bound to every instance.
// Assumes the port timing described for the top level.
module stp_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] phase_in,
    input logic [3:0] gate_en,
    input logic       cur_reduce,
    input logic [1:0] iref_code,
    input logic [1:0] ontime_code,
    input logic       open_loop,
    input logic       full_mode
);

    logic started = 1'b0;

    // Mark that at least one clock edge has occurred.
    always_ff @(posedge clk) started <= 1'b1;

    AST_PROG_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_in == 4'b0000) |=> ##1 (gate_en == 4'b0000 && !cur_reduce)); // R2

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_in == 4'b0000) |=> ##1 $stable({full_mode, open_loop, ontime_code, iref_code})); // R6

    AST_FULL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && full_mode)
        |-> (gate_en == $past(phase_in, 2) && !cur_reduce)); // R5

    AST_SIMPLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !full_mode |-> !(gate_en[0] && gate_en[1]) && !(gate_en[2] && gate_en[3])); // R4

    AST_RESET_CLEAR: assert property (@(posedge clk)
        (started && !$past(rst_n))
        |-> (gate_en == 4'b0000 && !cur_reduce && iref_code == 2'b00
             && ontime_code == 2'b00 && !open_loop && !full_mode)); // R7

endmodule

bind stp_ctl_top stp_ctl_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_in    (phase_in),
    .gate_en     (gate_en),
    .cur_reduce  (cur_reduce),
    .iref_code   (iref_code),
    .ontime_code (ontime_code),
    .open_loop   (open_loop),
    .full_mode   (full_mode)
);

// File: tb/test_stp_ctl_top.sv
// Self-checking bench for stp_ctl_top: directed corner cases followed by
// seeded random phase patterns and configuration loads.
module test_stp_ctl_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] phase_in = 4'b0000;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic [3:0] gate_en;
    logic       cur_reduce;
    logic [1:0] iref_code;
    logic [1:0] ontime_code;
    logic       open_loop;
    logic       full_mode;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    logic [3:0]  cur_phase = 4'b0000;
    logic [5:0]  exp_cfg = 6'd0;
    logic [5:0]  exp_shadow = 6'd0;
    int unsigned seed_dummy;

    stp_ctl_top i_stp_ctl_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_in    (phase_in),
        .ser_clk     (ser_clk),
        .ser_data    (ser_data),
        .gate_en     (gate_en),
        .cur_reduce  (cur_reduce),
        .iref_code   (iref_code),
        .ontime_code (ontime_code),
        .open_loop   (open_loop),
        .full_mode   (full_mode)
    );

    always #5 clk = ~clk;

    // Expected {cur_reduce, gate_en} from the requirements.
    function automatic logic [4:0] exp_drive(input logic [3:0] p, input logic [5:0] c);
        logic [3:0] g;
        if (p == 4'b0000) return 5'b0;                 // R1, R2
        if (c[5]) return {1'b0, p};                    // R5
        g = p[2] ? {~p[1], p[1], ~p[0], p[0]} : 4'b0;  // R4
        return {p[3], g};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_exports(input string tag);
        chk(tag, {2'b00, full_mode, open_loop, ontime_code, iref_code}, {2'b00, exp_cfg});
    endtask

    // Drive a phase pattern and check all outputs two edges later (R10).
    task automatic apply_phase(input logic [3:0] p);
        logic [4:0] e;
        @(negedge clk);
        phase_in = p;
        if (cur_phase == 4'b0000 && p != 4'b0000) exp_cfg = exp_shadow;  // R6 commit
        cur_phase = p;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        e = exp_drive(p, exp_cfg);
        if (p == 4'b0000)
            chk("R2 blanked drive", {3'b000, cur_reduce, gate_en}, {3'b000, e});
        else if (exp_cfg[5])
            chk("R5 full drive", {3'b000, cur_reduce, gate_en}, {3'b000, e});
        else
            chk("R4 simplified drive", {3'b000, cur_reduce, gate_en}, {3'b000, e});
        chk_exports("R8 R10 exports");
    endtask

    // Shift the low n bits of w, MSB first, on ser_clk rising edges (R3).
    task automatic shift_bits(input logic [5:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            ser_data = w[i];
            ser_clk  = 1'b0;
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
            if (cur_phase == 4'b0000) exp_shadow = {exp_shadow[4:0], w[i]};  // R1, R9
        end
        repeat (4) @(negedge clk);
        chk_exports("R6 exports held while loading");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        phase_in = 4'b0000;
        ser_clk = 1'b0;
        cur_phase = 4'b0000;
        exp_cfg = 6'd0;
        exp_shadow = 6'd0;
        repeat (3) @(negedge clk);
        chk("R7 reset drive", {3'b000, cur_reduce, gate_en}, 8'h00);
        chk_exports("R7 reset exports");
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'd20240611);
        do_reset();

        // R4: simplified mode, enable high, pair polarities 1 and 0.
        apply_phase(4'b0101);
        // R4: enable low blanks gates, reduction passes through.
        apply_phase(4'b1011);
        // R1 R2: all-low pattern opens the window.
        apply_phase(4'b0000);
        // R3: full word; R6: exports must hold while loading.
        shift_bits(6'b100110, 6);
        // R5 R8: commit gives full mode, iref=10, ontime=01, open_loop=0.
        apply_phase(4'b1010);
        apply_phase(4'b0111);
        // R9: serial edges outside the window leave the shadow word alone.
        shift_bits(6'b011111, 6);
        apply_phase(4'b0000);
        apply_phase(4'b0011);
        // R3: a partial load shifts into the existing shadow word.
        apply_phase(4'b0000);
        shift_bits(6'b000101, 3);
        apply_phase(4'b1100);
        // R4: return to simplified mode with open loop set.
        apply_phase(4'b0000);
        shift_bits(6'b010001, 6);
        apply_phase(4'b0110);

        // Random mix of phase patterns and configuration loads.
        for (int k = 0; k < 300; k++) begin
            int unsigned r;
            r = $urandom % 8;
            if (r == 0) begin
                apply_phase(4'b0000);
                shift_bits(6'($urandom), 1 + int'($urandom % 6));
            end else if (r == 1) begin
                apply_phase(4'b0000);
            end else begin
                apply_phase(4'($urandom));
            end
            if (k == 150) begin
                do_reset();  // R7: reset in the middle of operation
                apply_phase(4'b0100);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule